// File: doc/BRIEF.md
# Multilevel Interrupt Priority Controller

This block sits between a set of interrupt request lines and a processor core. Every request line comes with a two-bit level code that selects off, low, medium or high. A separate non-maskable request ranks above all three levels. On every cycle the controller works out which pending request it should show to the core. It presents that request as a vector number and a level, and it keeps one status bit for each level whose handler is currently running.

The core acknowledges a presented vector, and that marks the vector's level as executing. A return strobe retires the most recent, highest executing level. A new request is shown only when its level is above every level already executing, which lets handlers nest strictly by level.

At the low level, a mode input switches between two orderings. The first is fixed lowest-index-first. The second is a rotating order that puts the last acknowledged low-level source at the back of the queue. A sleep input adds a fixed wake-up delay before a pending request is shown.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `vec_valid` is 0, `lvl_active` is 0, and the rotation pointer holds source 0. Until the first low-level acknowledge, source 0 is therefore the last choice at the low level in rotating mode.
- R2: While `gie` is 0 no maskable vector is presented. `vec_valid` with `vec_nmi` 0 implies that `gie` was 1 in the cycle before.
- R3: `nmi_req` takes precedence over every maskable request and does not depend on `gie` or `lvl_en`. It is presented with `vec_nmi` 1, `vec_id` 0 and `vec_level` 4.
- R4: Source i takes its level from `src_lvl[2i+1:2i]`, coded 0 off, 1 low, 2 medium, 3 high. The highest enabled level with a pending request wins. The outputs are registered, so a request shows on `vec_valid` one cycle after it is applied.
- R5: Within the medium and high levels the lowest source index wins. The same holds at the low level while `rr_en` is 0.
- R6: `lvl_en[0]`, `lvl_en[1]` and `lvl_en[2]` enable low, medium and high. A cleared bit makes the requests of that level ignored.
- R7: A vector is presented only if its level (1 low, 2 medium, 3 high, 4 non-maskable) is above the highest level marked in `lvl_active`. Bit k-1 of `lvl_active` marks level k.
- R8: `ack` while `vec_valid` is 1 sets the `lvl_active` bit of the presented level and forces `vec_valid` to 0 in the next cycle. `ack` while `vec_valid` is 0 has no effect.
- R9: `reti` clears the highest set bit of `lvl_active`.
- R10: With `rr_en` 1, the low level picks the first pending low source above the last acknowledged low vector, searching upward and wrapping around.
- R11: The rotation pointer changes only when a low-level vector is acknowledged.
- R12: While `sleep` is 1, an eligible request reaches `vec_valid` five cycles later than it would while awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Request line per source |
| src_lvl | input | 2*NSRC | Two-bit level code per source |
| nmi_req | input | 1 | Non-maskable request |
| gie | input | 1 | Global enable for maskable requests |
| lvl_en | input | 3 | Per-level enables: low, medium, high |
| rr_en | input | 1 | Rotating order at the low level |
| sleep | input | 1 | Core asleep; adds the wake-up delay |
| ack | input | 1 | Core takes the presented vector |
| reti | input | 1 | Return from the current handler |
| vec_valid | output | 1 | A vector is presented |
| vec_id | output | IDW | Presented source index |
| vec_nmi | output | 1 | Presented vector is non-maskable |
| vec_level | output | 3 | Level of the presented vector, 1 to 4 |
| lvl_active | output | 4 | Executing levels: low, medium, high, non-maskable |

## Verification
The hardest state to reach is a three-deep nest in which rotating low-level arbitration continues after the nested handlers unwind. It needs acknowledges at rising levels, then returns in the right order, while several low sources stay pending across pointer updates. Directed phases build this nest on purpose and then unwind it. A long random phase follows, with sparse requests, random level codes and mode flips, and with acknowledges and returns drawn each cycle, so the pointer wraps and nests form and collapse many times. An independent model in the bench follows the active levels, the pointer and the wake counter, and every cycle is compared against it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        LV_OFF  = 2'd0,
        LV_LOW  = 2'd1,
        LV_MED  = 2'd2,
        LV_HIGH = 2'd3
    } lvl_code_e;

    localparam int NRANK  = 4;           // low, medium, high, non-maskable
    localparam int RANK_W = 3;           // ranks 0..4
    localparam logic [RANK_W-1:0] RANK_NMI = 3'd4;

    // highest set status bit as a rank, 0 when nothing executes
    function automatic logic [RANK_W-1:0] top_rank(input logic [NRANK-1:0] act);
        logic [RANK_W-1:0] r;
        r = '0;
        for (int k = 0; k < NRANK; k++) begin
            if (act[k]) r = RANK_W'(k + 1);
        end
        return r;
    endfunction

    function automatic logic [NRANK-1:0] rank_bit(input logic [RANK_W-1:0] r);
        logic [NRANK-1:0] b;
        b = '0;
        for (int k = 0; k < NRANK; k++) begin
            if (r == RANK_W'(k + 1)) b[k] = 1'b1;
        end
        return b;
    endfunction

endpackage

// File: rtl/irq_lvl_mask.sv
module irq_lvl_mask
    import irq_prio_pkg::*;
#(
    parameter int NSRC = 16
) (
    input  logic [NSRC-1:0]   req,
    input  logic [2*NSRC-1:0] lvl,
    input  logic              gie,
    input  logic [2:0]        lvl_en,
    output logic [NSRC-1:0]   low_m,
    output logic [NSRC-1:0]   med_m,
    output logic [NSRC-1:0]   high_m
);

    genvar i;
    generate
        for (i = 0; i < NSRC; i++) begin : g_src
            logic [1:0] code;
            logic       live;
            assign code      = lvl[2*i +: 2];
            assign live      = req[i] & gie;
            assign low_m[i]  = live & lvl_en[0] & (code == LV_LOW);
            assign med_m[i]  = live & lvl_en[1] & (code == LV_MED);
            assign high_m[i] = live & lvl_en[2] & (code == LV_HIGH);
        end
    endgenerate

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NSRC   = 16,
    parameter bit ROTATE = 1'b0,
    localparam int IDW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] mask,
    input  logic [IDW-1:0]  ptr,
    input  logic            rot_en,
    output logic            hit,
    output logic [IDW-1:0]  idx
);

    logic           fix_hit;
    logic [IDW-1:0] fix_idx;

    // lowest index first
    always_comb begin
        fix_hit = 1'b0;
        fix_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (mask[i]) begin
                fix_hit = 1'b1;
                fix_idx = IDW'(i);
            end
        end
    end

    generate
        if (ROTATE) begin : g_rot
            logic           rot_hit;
            logic [IDW-1:0] rot_idx;
            int             j;

            // search upward from the slot after ptr; ptr itself comes last
            always_comb begin
                rot_hit = 1'b0;
                rot_idx = '0;
                j       = 0;
                for (int k = 1; k <= NSRC; k++) begin
                    j = int'(ptr) + k;
                    if (j >= NSRC) j = j - NSRC;
                    if (!rot_hit && mask[j]) begin
                        rot_hit = 1'b1;
                        rot_idx = IDW'(j);
                    end
                end
            end

            assign hit = rot_en ? rot_hit : fix_hit;
            assign idx = rot_en ? rot_idx : fix_idx;
        end else begin : g_fix
            logic unused_ok;
            assign unused_ok = rot_en ^ (^ptr);
            assign hit = fix_hit;
            assign idx = fix_idx;
        end
    endgenerate

endmodule

// File: rtl/irq_lvl_status.sv
module irq_lvl_status
    import irq_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NRANK-1:0] set_bit,
    input  logic             reti,
    output logic [NRANK-1:0] active
);

    typedef struct packed {
        logic [NRANK-1:0] act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [NRANK-1:0] drop;
        st_d = st_q;
        drop = reti ? rank_bit(top_rank(st_q.act)) : '0;
        st_d.act = (st_q.act & ~drop) | set_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.act;

    AST_RETI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && set_bit == '0 && active != '0) |=> ($countones(active) == $countones($past(active)) - 1)); // R9

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bit != '0) |=> ((active & $past(set_bit)) == $past(set_bit))); // R8

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NSRC = 16,
    parameter int WAKE = 5,
    localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int WCW = $clog2(WAKE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_req,
    input  logic [2*NSRC-1:0] src_lvl,
    input  logic              nmi_req,
    input  logic              gie,
    input  logic [2:0]        lvl_en,
    input  logic              rr_en,
    input  logic              sleep,
    input  logic              ack,
    input  logic              reti,
    output logic              vec_valid,
    output logic [IDW-1:0]    vec_id,
    output logic              vec_nmi,
    output logic [2:0]        vec_level,
    output logic [3:0]        lvl_active
);

    typedef struct packed {
        logic              vld;
        logic              nmi;
        logic [IDW-1:0]    id;
        logic [RANK_W-1:0] rank;
        logic [IDW-1:0]    ptr;
        logic [WCW-1:0]    wcnt;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [NSRC-1:0]   low_m, med_m, high_m;
    logic              low_hit, med_hit, high_hit;
    logic [IDW-1:0]    low_idx, med_idx, high_idx;
    logic [NRANK-1:0]  act;
    logic [NRANK-1:0]  set_bit;
    logic              ack_take;
    logic [RANK_W-1:0] cand_rank;
    logic [IDW-1:0]    cand_id;
    logic              elig;
    logic              wake_ok;

    irq_lvl_mask #(.NSRC(NSRC)) u_mask (
        .req    (src_req),
        .lvl    (src_lvl),
        .gie    (gie),
        .lvl_en (lvl_en),
        .low_m  (low_m),
        .med_m  (med_m),
        .high_m (high_m)
    );

    irq_pick #(.NSRC(NSRC), .ROTATE(1'b1)) u_pick_low (
        .mask   (low_m),
        .ptr    (s_q.ptr),
        .rot_en (rr_en),
        .hit    (low_hit),
        .idx    (low_idx)
    );

    irq_pick #(.NSRC(NSRC), .ROTATE(1'b0)) u_pick_med (
        .mask   (med_m),
        .ptr    (s_q.ptr),
        .rot_en (1'b0),
        .hit    (med_hit),
        .idx    (med_idx)
    );

    irq_pick #(.NSRC(NSRC), .ROTATE(1'b0)) u_pick_high (
        .mask   (high_m),
        .ptr    (s_q.ptr),
        .rot_en (1'b0),
        .hit    (high_hit),
        .idx    (high_idx)
    );

    irq_lvl_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_bit (set_bit),
        .reti    (reti),
        .active  (act)
    );

    assign ack_take = ack & s_q.vld;
    assign set_bit  = ack_take ? rank_bit(s_q.rank) : '0;

    always_comb begin
        s_d       = s_q;
        cand_rank = '0;
        cand_id   = '0;

        if (nmi_req) begin
            cand_rank = RANK_NMI;
        end else if (high_hit) begin
            cand_rank = 3'd3;
            cand_id   = high_idx;
        end else if (med_hit) begin
            cand_rank = 3'd2;
            cand_id   = med_idx;
        end else if (low_hit) begin
            cand_rank = 3'd1;
            cand_id   = low_idx;
        end

        elig    = (cand_rank > top_rank(act));
        wake_ok = !sleep || (s_q.wcnt == WCW'(WAKE));

        if (elig && sleep) begin
            if (s_q.wcnt != WCW'(WAKE)) s_d.wcnt = s_q.wcnt + 1'b1;
        end else begin
            s_d.wcnt = '0;
        end

        s_d.vld  = elig && wake_ok && !ack_take;
        s_d.nmi  = s_d.vld && (cand_rank == RANK_NMI);
        s_d.id   = s_d.vld ? cand_id : '0;
        s_d.rank = s_d.vld ? cand_rank : '0;

        if (ack_take && s_q.rank == 3'd1) s_d.ptr = s_q.id;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign vec_valid  = s_q.vld;
    assign vec_id     = s_q.id;
    assign vec_nmi    = s_q.nmi;
    assign vec_level  = s_q.rank;
    assign lvl_active = act;

    AST_MASKABLE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_nmi) |-> $past(gie)); // R2

    AST_NMI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && $past(nmi_req)) |-> (vec_nmi && vec_level == 3'd4)); // R3

    AST_ABOVE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_level > top_rank($past(lvl_active)))); // R7

    AST_ACK_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && vec_valid) |=> !vec_valid); // R8

    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && vec_valid && vec_level == 3'd1) |=> $stable(s_q.ptr)); // R11

    AST_SLEEP_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vec_valid) && $past(sleep)) |-> ($past(s_q.wcnt) == WCW'(WAKE))); // R12

endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;

    localparam int NSRC = 16;
    localparam int IDW  = 4;
    localparam int WAKE = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_req = '0;
    logic [2*NSRC-1:0] src_lvl = '0;
    logic              nmi_req = 1'b0;
    logic              gie = 1'b0;
    logic [2:0]        lvl_en = 3'b111;
    logic              rr_en = 1'b0;
    logic              sleep = 1'b0;
    logic              ack = 1'b0;
    logic              reti = 1'b0;
    logic              vec_valid;
    logic [IDW-1:0]    vec_id;
    logic              vec_nmi;
    logic [2:0]        vec_level;
    logic [3:0]        lvl_active;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // bench model state
    logic [3:0] m_act = '0;
    int         m_ptr = 0;
    int         m_cnt = 0;
    logic       m_vld = 1'b0;
    int         m_id = 0;
    int         m_rank = 0;

    always #10 clk = ~clk;

    irq_prio_ctrl #(.NSRC(NSRC), .WAKE(WAKE)) u0 (
        .clk, .rst_n, .src_req, .src_lvl, .nmi_req, .gie, .lvl_en, .rr_en,
        .sleep, .ack, .reti, .vec_valid, .vec_id, .vec_nmi, .vec_level, .lvl_active
    );

    function automatic int top_of(input logic [3:0] a);
        int r = 0;
        for (int k = 0; k < 4; k++) if (a[k]) r = k + 1;
        return r;
    endfunction

    function automatic int lvl_of(input int i);
        return int'(src_lvl[2*i +: 2]);
    endfunction

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic check(input string tag, input bit ok, input string got, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got %s expected %s", tag, got, exp);
        end
    endtask

    // one clock with the current inputs; model predicts, then compares
    task automatic step(input string tag);
        int crk = 0, cid = 0, nc, np;
        bit ackd, elig, ev, found;
        logic [3:0] na;
        if (nmi_req) crk = 4;
        else if (gie) begin
            for (int lv = 3; lv >= 1 && crk == 0; lv--) begin
                if (lvl_en[lv-1]) begin
                    found = 0;
                    if (lv == 1 && rr_en) begin
                        for (int k = 1; k <= NSRC; k++) begin
                            int j = (m_ptr + k) % NSRC;
                            if (!found && src_req[j] && lvl_of(j) == 1) begin
                                found = 1; cid = j;
                            end
                        end
                    end else begin
                        for (int i = NSRC - 1; i >= 0; i--)
                            if (src_req[i] && lvl_of(i) == lv) begin found = 1; cid = i; end
                    end
                    if (found) crk = lv;
                end
            end
        end
        ackd = ack && m_vld;
        elig = crk > top_of(m_act);
        nc   = (elig && sleep) ? ((m_cnt == WAKE) ? WAKE : m_cnt + 1) : 0;
        ev   = elig && (!sleep || m_cnt == WAKE) && !ackd;
        na   = m_act;
        if (reti) begin
            for (int k = 3; k >= 0; k--) if (na[k]) begin na[k] = 1'b0; break; end
        end
        if (ackd) na[m_rank-1] = 1'b1;
        np = (ackd && m_rank == 1) ? m_id : m_ptr;
        @(posedge clk);
        #2;
        m_act = na; m_ptr = np; m_cnt = nc; m_vld = ev;
        m_id = ev ? cid : 0; m_rank = ev ? crk : 0;
        check(tag,
              vec_valid == ev && lvl_active == na &&
              (!ev || (int'(vec_id) == m_id && int'(vec_level) == m_rank && vec_nmi == (crk == 4))),
              $sformatf("v=%0b id=%0d lv=%0d nmi=%0b act=%b", vec_valid, vec_id, vec_level, vec_nmi, lvl_active),
              $sformatf("v=%0b id=%0d lv=%0d nmi=%0b act=%b", ev, m_id, m_rank, crk == 4, na));
    endtask

    task automatic set_src(input int i, input int lv, input bit on);
        src_lvl[2*i +: 2] = 2'(lv);
        src_req[i] = on;
    endtask

    task automatic quiet();
        src_req = '0; nmi_req = 0; ack = 0; reti = 0; sleep = 0;
        step("R9");
        while (m_act != 0) begin reti = 1; step("R9"); end
        reti = 0;
        step("R1");
    endtask

    task automatic take(input string tag);
        ack = 1; step(tag); ack = 0;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                total++; bad++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        check("R1", vec_valid == 0 && lvl_active == 0, $sformatf("v=%0b act=%b", vec_valid, lvl_active), "v=0 act=0000");
        rst_n = 1;
        step("R1");

        // R4: level order, registered output
        gie = 1;
        set_src(3, 1, 1); set_src(5, 3, 1); set_src(1, 2, 1);
        step("R4"); step("R4");
        // R5: lowest index within a level
        src_req = '0; set_src(9, 2, 1); set_src(6, 2, 1); set_src(12, 2, 1);
        step("R5"); step("R5");
        // R2: gie cleared; R3: NMI still wins
        gie = 0; step("R2"); step("R2");
        nmi_req = 1; step("R3"); step("R3");
        gie = 1; lvl_en = 3'b000; step("R3");
        take("R8"); nmi_req = 0; step("R7"); step("R7");
        lvl_en = 3'b111;
        quiet();

        // R6: per-level enables
        gie = 1; set_src(2, 1, 1); set_src(4, 2, 1);
        lvl_en = 3'b101; step("R6"); step("R6");
        lvl_en = 3'b001; step("R6");
        lvl_en = 3'b110; src_req = '0; set_src(2, 1, 1); step("R6"); step("R6");
        lvl_en = 3'b111; step("R6");
        quiet();

        // R7, R8, R9: nest low -> med -> high, then unwind
        set_src(2, 1, 1); step("R7");
        ack = 1; reti = 0; step("R8"); ack = 0;     // not valid yet? model decides
        if (!m_vld) step("R8");
        take("R8"); src_req[2] = 0; step("R8");
        set_src(7, 1, 1); step("R7"); step("R7");   // low blocked by active low
        set_src(8, 2, 1); step("R7"); take("R8"); src_req[8] = 0;
        set_src(0, 3, 1); step("R7"); take("R8"); src_req[0] = 0;
        step("R7");
        reti = 1; step("R9"); reti = 0; step("R9");
        reti = 1; step("R9"); reti = 0; step("R9");
        src_req = '0;
        quiet();

        // R10, R11: rotation at the low level
        rr_en = 1;
        set_src(0, 1, 1); set_src(3, 1, 1); set_src(10, 1, 1); set_src(15, 1, 1);
        step("R1"); step("R10");
        for (int n = 0; n < 6; n++) begin
            if (m_vld) take("R10"); else step("R10");
            reti = 1; step("R9"); reti = 0;
            step("R10");
        end
        set_src(5, 2, 1); step("R11"); take("R11"); src_req[5] = 0;
        reti = 1; step("R11"); reti = 0; step("R11"); step("R10");
        rr_en = 0; step("R5"); step("R5");
        src_req = '0;
        quiet();

        // R12: wake-up delay while asleep
        sleep = 1; set_src(11, 3, 1);
        for (int n = 0; n < 9; n++) step("R12");
        take("R12"); src_req = '0;
        quiet();
        set_src(11, 3, 1); step("R12"); step("R12");
        quiet();

        // random mix
        for (int n = 0; n < 6000; n++) begin
            for (int i = 0; i < NSRC; i++) begin
                if ($urandom_range(0, 7) == 0) set_src(i, int'($urandom_range(0, 3)), ~src_req[i]);
            end
            nmi_req = ($urandom_range(0, 40) == 0);
            gie     = ($urandom_range(0, 9) != 0);
            if ($urandom_range(0, 30) == 0) lvl_en = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 60) == 0) rr_en = ~rr_en;
            if ($urandom_range(0, 80) == 0) sleep = ~sleep;
            ack  = m_vld && ($urandom_range(0, 1) == 1);
            reti = (m_act != 0) && ($urandom_range(0, 4) == 0);
            step("R4");
        end
        ack = 0; reti = 0;
        finish_run();
    end

endmodule